// File: doc/BRIEF.md
# Channel-Indexed Record/Playback Address Sequencer

This block steers recording and playback of 4-bit ADPCM samples held in an external memory. The memory is organised as words of 256 nibbles. An X address selects a word and an 8-bit Y address selects a nibble inside it. The first 32 words hold a channel directory, one word per channel. Each directory entry is a 40-bit record. The record carries the channel's start word, then its stop nibble, then its stop word. Voice data lives from word 020h upward.

Software-side logic loads three address registers: start X, stop X and stop Y. It can then ask the block to copy those registers into a channel's directory entry, or to copy a directory entry back into the registers. A record or play command starts a counter at (start X, 00h) and advances it by one nibble per sample strobe until the stop position is reached. A stop command can also end the run early. `busy` is high during a directory transfer, and `rpm` is high while a record or playback run is active. The memory is reached through a simple request/acknowledge port that moves either one directory byte or one sample nibble per transaction.

Top module: `chanRecSeq`

## Requirements
- R1: After reset `busy`, `rpm`, `memReq` and `playValid` are 0, and the start and stop registers read as 0.
- R2: A `regWrEn` pulse while idle loads `startXIn`, `stopXIn` and `stopYIn`. The new values show on `startXOut`, `stopXOut` and `stopYOut` after the next rising edge. The pulse has no effect while `busy` or `rpm` is 1.
- R3: An `idxValid` pulse with `idxWrite`=1 raises `busy` and issues five byte writes (`memIdx`=1) to word X = `chanSel`, at byte offsets Y = 0,1,2,3,4 in that order. The bytes are: start X bits 7:0, start X bits 12:8, stop Y, stop X bits 7:0, stop X bits 12:8. `busy` falls after the fifth acknowledge.
- R4: With `idxWrite`=0 the same five bytes are read in the same order and loaded into the registers. The upper 3 bits of the two high bytes are discarded.
- R5: `cmd`=10 (record) or 01 (play), with `cmdValid` while idle, sets the counter to (start X, 00h) and raises `rpm` after the edge. If the start position equals (stop X, stop Y), nothing starts.
- R6: Each `sampleStrobe` while `rpm` is 1 and no access is pending makes one access at the counter position. Record writes `recSample` into data bits 3:0. Play returns data bits 3:0 on `playSample`, with `playValid` high one cycle after the acknowledge. The counter then advances: Y steps, and on wrap from FFh to 00h X steps.
- R7: When the stop position is not below the start, the run ends when the advanced counter equals the stop position; that position itself is not accessed. `rpm` falls at the edge of the final acknowledge.
- R8: When the stop position is below the start, the run continues through the last nibble of memory (last X, FFh) and then ends. `memSize` selects the last X: 0 gives 3FFh, 1 gives FFFh, 2 or 3 gives 1FFFh.
- R9: `cmd`=11 during a run ends it and copies the counter into the stop registers, so a later directory write stores it. Without a pending access `rpm` falls at that edge. With a pending access, the access completes, the counter advances, and `rpm` falls one edge later.
- R10: `memReq` is only high while `busy` or `rpm` is 1. Once raised, it stays high with a stable address and direction until `memAck`.
- R11: Directory requests and register loads are ignored while `rpm` is 1. Every command is ignored while `busy` is 1, and record/play commands are ignored while `rpm` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| memSize | input | 2 | Memory capacity select |
| regWrEn | input | 1 | Load the address registers |
| startXIn | input | 13 | Start word to load |
| stopXIn | input | 13 | Stop word to load |
| stopYIn | input | 8 | Stop nibble to load |
| startXOut | output | 13 | Start word register |
| stopXOut | output | 13 | Stop word register |
| stopYOut | output | 8 | Stop nibble register |
| idxValid | input | 1 | Directory transfer request |
| idxWrite | input | 1 | 1: registers to directory, 0: directory to registers |
| chanSel | input | 5 | Channel number |
| cmdValid | input | 1 | Command strobe |
| cmd | input | 2 | 00 none, 01 play, 10 record, 11 stop |
| sampleStrobe | input | 1 | Sample-rate tick |
| recSample | input | 4 | Nibble to record |
| playSample | output | 4 | Played nibble |
| playValid | output | 1 | Played nibble valid pulse |
| busy | output | 1 | Directory transfer in progress |
| rpm | output | 1 | Record or playback run active |
| curX | output | 13 | Counter word |
| curY | output | 8 | Counter nibble |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Memory write |
| memIdx | output | 1 | 1: directory byte access, 0: sample nibble access |
| memX | output | 13 | Memory word address |
| memY | output | 8 | Nibble index, or byte offset for directory access |
| memWdata | output | 8 | Write data |
| memRdata | input | 8 | Read data, valid with memAck |
| memAck | input | 1 | Memory acknowledge |

## Verification
The bench targets run lengths that cross a word boundary. An off-by-one in the Y wrap or in the stop comparison would show up as one sample too many or too few, or as a counter left on the wrong nibble. Runs whose stop lies below their start are run under each memory size. A design that compared only X, or that used the wrong last word, would end early or never. A stop issued while an access is outstanding checks that the snapshot taken for the directory is the advanced counter and not the stale one. Directory round trips with junk in the unused high bits check byte order and masking. Commands and register loads are also sent during `busy` or `rpm`, where a design that honoured them would start a second run or overwrite the addresses.

// File: rtl/recseq_pkg.sv
package recseq_pkg;
  typedef enum logic [1:0] {
    CMD_NOP  = 2'b00,
    CMD_PLAY = 2'b01,
    CMD_REC  = 2'b10,
    CMD_STOP = 2'b11
  } cmdE;

  typedef enum logic [1:0] {S_IDLE, S_IDX, S_RUN, S_ACC} stateE;

  // strobes from control to datapath
  typedef struct packed {
    logic loadRegs;
    logic startRun;
    logic stepCount;
    logic clrByte;
    logic nextByte;
    logic capByte;
    logic snapStop;
    logic capRec;
    logic emitPlay;
  } strobeS;

  localparam int NBYTES = 5;
endpackage

// File: rtl/recSeqCtrl.sv
module recSeqCtrl
  import recseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [1:0] cmd,
  input  logic       idxValid,
  input  logic       idxWrite,
  input  logic       regWrEn,
  input  logic       sampleStrobe,
  input  logic       memAck,
  input  logic       runDone,
  input  logic       startEmpty,
  input  logic       lastByte,
  output strobeS     st,
  output logic       busy,
  output logic       rpm,
  output logic       memReq,
  output logic       memWe,
  output logic       memIdx
);
  stateE state, nxtState;
  logic  wrOp, recOp, stopPend;
  logic  isStop, isRun;

  assign isStop = cmdValid && (cmd == CMD_STOP);
  assign isRun  = cmdValid && ((cmd == CMD_PLAY) || (cmd == CMD_REC));

  always_comb begin
    st       = '0;
    nxtState = state;
    memReq   = 1'b0;
    memWe    = 1'b0;
    memIdx   = 1'b0;
    case (state)
      S_IDLE: begin
        if (idxValid) begin
          st.clrByte = 1'b1;
          nxtState   = S_IDX;
        end else if (isRun) begin
          if (!startEmpty) begin
            st.startRun = 1'b1;
            nxtState    = S_RUN;
          end
        end else if (regWrEn) begin
          st.loadRegs = 1'b1;
        end
      end
      S_IDX: begin
        memReq = 1'b1;
        memWe  = wrOp;
        memIdx = 1'b1;
        if (memAck) begin
          st.capByte = !wrOp;
          if (lastByte) nxtState = S_IDLE;
          else          st.nextByte = 1'b1;
        end
      end
      S_RUN: begin
        if (stopPend || isStop) begin
          st.snapStop = 1'b1;
          nxtState    = S_IDLE;
        end else if (sampleStrobe) begin
          st.capRec = 1'b1;
          nxtState  = S_ACC;
        end
      end
      S_ACC: begin
        memReq = 1'b1;
        memWe  = recOp;
        if (memAck) begin
          st.emitPlay  = !recOp;
          st.stepCount = 1'b1;
          nxtState     = runDone ? S_IDLE : S_RUN;
        end
      end
      default: nxtState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      wrOp     <= 1'b0;
      recOp    <= 1'b0;
      stopPend <= 1'b0;
    end else begin
      state <= nxtState;
      if (st.clrByte)  wrOp  <= idxWrite;
      if (st.startRun) recOp <= (cmd == CMD_REC);
      if (state == S_ACC && memAck && runDone) stopPend <= 1'b0;
      else if (state == S_ACC && isStop)       stopPend <= 1'b1;
      else if (state == S_RUN)                 stopPend <= 1'b0;
    end
  end

  assign busy = (state == S_IDX);
  assign rpm  = (state == S_RUN) || (state == S_ACC);
endmodule

// File: rtl/recSeqData.sv
module recSeqData
  import recseq_pkg::*;
#(
  parameter int XW  = 13,
  parameter int YW  = 8,
  parameter int CHW = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobeS        st,
  input  logic          memIdx,
  input  logic [1:0]    memSize,
  input  logic [XW-1:0] startXIn,
  input  logic [XW-1:0] stopXIn,
  input  logic [YW-1:0] stopYIn,
  input  logic [CHW-1:0] chanSel,
  input  logic [3:0]    recSample,
  input  logic [7:0]    memRdata,
  output logic [XW-1:0] startXOut,
  output logic [XW-1:0] stopXOut,
  output logic [YW-1:0] stopYOut,
  output logic [XW-1:0] curX,
  output logic [YW-1:0] curY,
  output logic [XW-1:0] memX,
  output logic [YW-1:0] memY,
  output logic [7:0]    memWdata,
  output logic [3:0]    playSample,
  output logic          playValid,
  output logic          runDone,
  output logic          startEmpty,
  output logic          lastByte
);
  localparam int AW  = XW + YW;
  localparam int HIW = XW - 8;
  localparam int BIW = $clog2(NBYTES);

  logic [XW-1:0]  startX, stopX, lastX;
  logic [YW-1:0]  stopY;
  logic [CHW-1:0] chan;
  logic [BIW-1:0] byteIdx;
  logic           toEnd;
  logic [3:0]     recNib;
  logic [AW-1:0]  curAddr, nxtAddr, stopAddr, startAddr;
  logic           atLast;
  logic [7:0]     byteOut;

  always_comb begin
    case (memSize)
      2'd0:    lastX = XW'((1 << 10) - 1);
      2'd1:    lastX = XW'((1 << 12) - 1);
      default: lastX = XW'((1 << 13) - 1);
    endcase
  end

  assign curAddr    = {curX, curY};
  assign nxtAddr    = curAddr + AW'(1);
  assign stopAddr   = {stopX, stopY};
  assign startAddr  = {startX, {YW{1'b0}}};
  assign atLast     = (curX == lastX) && (curY == {YW{1'b1}});
  assign runDone    = atLast || (!toEnd && (nxtAddr == stopAddr));
  assign startEmpty = (startAddr == stopAddr);
  assign lastByte   = (byteIdx == BIW'(NBYTES - 1));

  always_comb begin
    case (byteIdx)
      BIW'(0): byteOut = startX[7:0];
      BIW'(1): byteOut = 8'({startX[XW-1:8]});
      BIW'(2): byteOut = 8'(stopY);
      BIW'(3): byteOut = stopX[7:0];
      default: byteOut = 8'({stopX[XW-1:8]});
    endcase
  end

  assign memX     = memIdx ? XW'(chan) : curX;
  assign memY     = memIdx ? YW'(byteIdx) : curY;
  assign memWdata = memIdx ? byteOut : {4'b0000, recNib};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startX     <= '0;
      stopX      <= '0;
      stopY      <= '0;
      curX       <= '0;
      curY       <= '0;
      chan       <= '0;
      byteIdx    <= '0;
      toEnd      <= 1'b0;
      recNib     <= '0;
      playSample <= '0;
      playValid  <= 1'b0;
    end else begin
      playValid <= st.emitPlay;
      if (st.emitPlay) playSample <= memRdata[3:0];
      if (st.capRec)   recNib     <= recSample;
      if (st.loadRegs) begin
        startX <= startXIn;
        stopX  <= stopXIn;
        stopY  <= stopYIn;
      end
      if (st.clrByte) begin
        byteIdx <= '0;
        chan    <= chanSel;
      end
      if (st.nextByte) byteIdx <= byteIdx + BIW'(1);
      if (st.capByte) begin
        case (byteIdx)
          BIW'(0): startX[7:0]    <= memRdata;
          BIW'(1): startX[XW-1:8] <= memRdata[HIW-1:0];
          BIW'(2): stopY          <= YW'(memRdata);
          BIW'(3): stopX[7:0]     <= memRdata;
          default: stopX[XW-1:8]  <= memRdata[HIW-1:0];
        endcase
      end
      if (st.startRun) begin
        curX  <= startX;
        curY  <= '0;
        toEnd <= (stopAddr < startAddr);
      end
      if (st.stepCount && !atLast) {curX, curY} <= nxtAddr;
      if (st.snapStop) begin
        stopX <= curX;
        stopY <= curY;
      end
    end
  end

  assign startXOut = startX;
  assign stopXOut  = stopX;
  assign stopYOut  = stopY;
endmodule

// File: rtl/chanRecSeq.sv
module chanRecSeq
  import recseq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  memSize,
  input  logic        regWrEn,
  input  logic [12:0] startXIn,
  input  logic [12:0] stopXIn,
  input  logic [7:0]  stopYIn,
  output logic [12:0] startXOut,
  output logic [12:0] stopXOut,
  output logic [7:0]  stopYOut,
  input  logic        idxValid,
  input  logic        idxWrite,
  input  logic [4:0]  chanSel,
  input  logic        cmdValid,
  input  logic [1:0]  cmd,
  input  logic        sampleStrobe,
  input  logic [3:0]  recSample,
  output logic [3:0]  playSample,
  output logic        playValid,
  output logic        busy,
  output logic        rpm,
  output logic [12:0] curX,
  output logic [7:0]  curY,
  output logic        memReq,
  output logic        memWe,
  output logic        memIdx,
  output logic [12:0] memX,
  output logic [7:0]  memY,
  output logic [7:0]  memWdata,
  input  logic [7:0]  memRdata,
  input  logic        memAck
);
  strobeS st;
  logic   runDone, startEmpty, lastByte;

  recSeqCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmd(cmd),
    .idxValid(idxValid), .idxWrite(idxWrite), .regWrEn(regWrEn),
    .sampleStrobe(sampleStrobe), .memAck(memAck), .runDone(runDone),
    .startEmpty(startEmpty), .lastByte(lastByte), .st(st),
    .busy(busy), .rpm(rpm), .memReq(memReq), .memWe(memWe), .memIdx(memIdx)
  );

  recSeqData #(.XW(13), .YW(8), .CHW(5)) u_data (
    .clk(clk), .rstN(rstN), .st(st), .memIdx(memIdx), .memSize(memSize),
    .startXIn(startXIn), .stopXIn(stopXIn), .stopYIn(stopYIn),
    .chanSel(chanSel), .recSample(recSample), .memRdata(memRdata),
    .startXOut(startXOut), .stopXOut(stopXOut), .stopYOut(stopYOut),
    .curX(curX), .curY(curY), .memX(memX), .memY(memY),
    .memWdata(memWdata), .playSample(playSample), .playValid(playValid),
    .runDone(runDone), .startEmpty(startEmpty), .lastByte(lastByte)
  );
endmodule

// File: rtl/chanRecSeqChecker.sv
module chanRecSeqChecker (
  input logic        clk,
  input logic        rstN,
  input logic        idxValid,
  input logic        busy,
  input logic        rpm,
  input logic        memReq,
  input logic        memWe,
  input logic        memIdx,
  input logic [12:0] memX,
  input logic [7:0]  memY,
  input logic [7:0]  memWdata,
  input logic        memAck,
  input logic        playValid
);
  assert_busy_rpm_excl_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && rpm));

  assert_req_owner_R10: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (busy || rpm));

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memX) && $stable(memY) && $stable(memWe)));

  assert_idx_start_R3: assert property (@(posedge clk) disable iff (!rstN)
    (idxValid && !busy && !rpm) |=> busy);

  assert_idx_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memIdx) |-> ((memX < 13'd32) && (memY < 8'd5)));

  assert_rec_nibble_R6: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memIdx && memWe) |-> (memWdata[7:4] == 4'h0));

  assert_play_after_ack_R6: assert property (@(posedge clk) disable iff (!rstN)
    playValid |-> ($past(memAck) && !$past(memWe)));
endmodule

bind chanRecSeq chanRecSeqChecker u_chk (.*);

// File: tb/sim_chanRecSeq.sv
module sim_chanRecSeq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  memSize = 2'd0;
  logic        regWrEn = 1'b0;
  logic [12:0] startXIn = '0, stopXIn = '0;
  logic [7:0]  stopYIn = '0;
  logic [12:0] startXOut, stopXOut, curX, memX;
  logic [7:0]  stopYOut, curY, memY, memWdata;
  logic        idxValid = 1'b0, idxWrite = 1'b0;
  logic [4:0]  chanSel = '0;
  logic        cmdValid = 1'b0;
  logic [1:0]  cmd = '0;
  logic        sampleStrobe = 1'b0;
  logic [3:0]  recSample = '0, playSample;
  logic        playValid, busy, rpm, memReq, memWe, memIdx;
  logic [7:0]  memRdata = '0;
  logic        memAck = 1'b0;

  int nChk = 0, nFail = 0, cyc = 0;
  logic [7:0]  idxMem [32][5];
  logic [3:0]  smem [int];
  logic [20:0] trackA = '0;
  int          lat = 0;
  logic [3:0]  recQ[$], playQ[$];

  chanRecSeq u0 (.*);

  always #10 clk = ~clk;

  task automatic chk(input string req, input longint act, input longint exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model with random acknowledge latency
  always @(posedge clk) begin
    memAck <= 1'b0;
    if (rstN && memReq && !memAck) begin
      if (lat == 0) begin
        memAck <= 1'b1;
        lat = $urandom_range(0, 2);
        if (memIdx) begin
          if (memWe) idxMem[memX[4:0]][memY[2:0]] = memWdata;
          else       memRdata <= idxMem[memX[4:0]][memY[2:0]];
        end else begin
          chk("R6 access address", {memX, memY}, trackA);
          if (memWe) smem[int'({memX, memY})] = memWdata[3:0];
          else memRdata <= {4'h0, smem.exists(int'({memX, memY})) ? smem[int'({memX, memY})] : 4'h0};
          trackA = trackA + 21'd1;
        end
      end else lat = lat - 1;
    end
  end

  always @(negedge clk) if (playValid) playQ.push_back(playSample);

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nFail++;
      $display("FAIL watchdog all-reqs actual=%0d expected<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setRegs(input logic [12:0] sx, input logic [12:0] px, input logic [7:0] py);
    startXIn = sx; stopXIn = px; stopYIn = py; regWrEn = 1'b1;
    tick(1);
    regWrEn = 1'b0;
  endtask

  task automatic waitIdle();
    int g = 0;
    while ((busy || rpm) && g < 5000) begin tick(1); g++; end
  endtask

  task automatic idxOp(input logic wr, input logic [4:0] ch);
    idxValid = 1'b1; idxWrite = wr; chanSel = ch;
    tick(1);
    idxValid = 1'b0;
    waitIdle();
  endtask

  task automatic sendCmd(input logic [1:0] c);
    cmdValid = 1'b1; cmd = c;
    tick(1);
    cmdValid = 1'b0;
  endtask

  task automatic strobes(input int maxN, input bit rec, output int n);
    n = 0;
    while (rpm && n < maxN) begin
      recSample = 4'($urandom);
      if (rec) recQ.push_back(recSample);
      sampleStrobe = 1'b1;
      tick(1);
      sampleStrobe = 1'b0;
      tick(7);
      n++;
    end
  endtask

  function automatic logic [39:0] recBytes(input logic [12:0] sx, input logic [7:0] py, input logic [12:0] px);
    return {3'b0, px[12:8], px[7:0], py, 3'b0, sx[12:8], sx[7:0]};
  endfunction

  initial begin
    int n;
    logic [12:0] sx, px;
    logic [7:0]  py;
    logic [4:0]  ch;
    process::self().srandom(32'd1234);
    for (int c = 0; c < 32; c++) for (int b = 0; b < 5; b++) idxMem[c][b] = 8'h00;

    tick(3);
    chk("R1 busy", busy, 0);
    chk("R1 rpm", rpm, 0);
    chk("R1 memReq", memReq, 0);
    chk("R1 stopX", stopXOut, 0);
    rstN = 1'b1;
    tick(1);
    chk("R1 playValid", playValid, 0);

    // random directory round trips
    for (int i = 0; i < 8; i++) begin
      ch = 5'($urandom); sx = 13'($urandom); px = 13'($urandom); py = 8'($urandom);
      setRegs(sx, px, py);
      chk("R2 startX load", startXOut, sx);
      idxOp(1'b1, ch);
      chk("R3 record bytes", {idxMem[ch][4], idxMem[ch][3], idxMem[ch][2], idxMem[ch][1], idxMem[ch][0]},
          recBytes(sx, py, px));
      idxMem[ch][1] = idxMem[ch][1] | 8'he0;
      idxMem[ch][4] = idxMem[ch][4] | 8'he0;
      setRegs(13'($urandom), 13'($urandom), 8'($urandom));
      idxOp(1'b0, ch);
      chk("R4 startX read", startXOut, sx);
      chk("R4 stopX read", stopXOut, px);
      chk("R4 stopY read", stopYOut, py);
    end

    // record across a word boundary, then play it back
    memSize = 2'd0;
    setRegs(13'h040, 13'h041, 8'h05);
    trackA = {13'h040, 8'h00};
    recQ.delete();
    sendCmd(2'b10);
    chk("R5 rpm rises", rpm, 1);
    chk("R5 counter start", {curX, curY}, {13'h040, 8'h00});
    strobes(400, 1'b1, n);
    chk("R7 sample count", n, 261);
    chk("R7 rpm falls", rpm, 0);
    chk("R7 counter at stop", {curX, curY}, {13'h041, 8'h05});
    trackA = {13'h040, 8'h00};
    playQ.delete();
    sendCmd(2'b01);
    strobes(400, 1'b0, n);
    tick(2);
    chk("R6 play count", playQ.size(), 261);
    begin
      int bad = 0;
      for (int k = 0; k < 261 && k < playQ.size(); k++) if (playQ[k] != recQ[k]) bad++;
      chk("R6 played data", bad, 0);
    end

    // constrained random short runs
    for (int i = 0; i < 4; i++) begin
      int len = $urandom_range(1, 40);
      sx = 13'($urandom_range(32, 1000));
      setRegs(sx, sx, 8'(len));
      trackA = {sx, 8'h00};
      sendCmd(i[0] ? 2'b01 : 2'b10);
      strobes(100, 1'b0, n);
      chk("R7 random length", n, len);
      chk("R7 random end", {curX, curY}, {sx, 8'(len)});
    end

    // ignored requests during a run, then stop
    setRegs(13'h100, 13'h120, 8'h00);
    trackA = {13'h100, 8'h00};
    sendCmd(2'b10);
    setRegs(13'h555, 13'h666, 8'h77);
    chk("R2 load ignored in run", stopXOut, 13'h120);
    idxValid = 1'b1; chanSel = 5'd9; idxWrite = 1'b1;
    tick(1);
    idxValid = 1'b0;
    chk("R11 index ignored in run", busy, 0);
    strobes(10, 1'b0, n);
    sendCmd(2'b11);
    chk("R9 rpm after stop", rpm, 0);
    chk("R9 snapshot", {stopXOut, stopYOut}, {13'h100, 8'h0a});
    idxOp(1'b1, 5'd7);
    chk("R9 stored stop", {idxMem[7][4][4:0], idxMem[7][3], idxMem[7][2]}, {13'h100, 8'h0a});

    // stop while an access is pending
    setRegs(13'h200, 13'h210, 8'h00);
    trackA = {13'h200, 8'h00};
    sendCmd(2'b10);
    sampleStrobe = 1'b1;
    tick(1);
    sampleStrobe = 1'b0;
    sendCmd(2'b11);
    tick(8);
    chk("R9 pending stop rpm", rpm, 0);
    chk("R9 pending snapshot", {stopXOut, stopYOut}, {13'h200, 8'h01});

    // stop below start: run to end of memory for each size
    setRegs(13'h3fe, 13'h030, 8'h00);
    trackA = {13'h3fe, 8'h00};
    sendCmd(2'b10);
    strobes(700, 1'b0, n);
    chk("R8 1K count", n, 512);
    chk("R8 1K end", {curX, curY}, {13'h3ff, 8'hff});
    memSize = 2'd1;
    setRegs(13'hfff, 13'h030, 8'h00);
    trackA = {13'hfff, 8'h00};
    sendCmd(2'b01);
    strobes(400, 1'b0, n);
    chk("R8 4K count", n, 256);
    memSize = 2'd2;
    setRegs(13'h1fff, 13'h030, 8'h00);
    trackA = {13'h1fff, 8'h00};
    sendCmd(2'b10);
    strobes(400, 1'b0, n);
    chk("R8 8K count", n, 256);
    chk("R8 8K end", {curX, curY}, {13'h1fff, 8'hff});

    // empty range does not start
    setRegs(13'h050, 13'h050, 8'h00);
    sendCmd(2'b01);
    chk("R5 empty range", rpm, 0);

    // command during busy is ignored
    setRegs(13'h060, 13'h070, 8'h00);
    idxValid = 1'b1; idxWrite = 1'b1; chanSel = 5'd3;
    tick(1);
    idxValid = 1'b0;
    chk("R3 busy raised", busy, 1);
    sendCmd(2'b01);
    waitIdle();
    chk("R11 command ignored while busy", rpm, 0);

    tick(4);
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule